// File: doc/BRIEF.md
# Filtered Quadrature Input Decoder

This block sits between the raw two-phase inputs of one encoder axis and a position counter. The two lines first pass through a synchronizer. A digital filter then accepts a new level only after sampling it twice in a row. The sample rate comes from a programmable prescaler, so the filter can be matched to the noise of the cable and encoder in use.

A decoder turns the filtered levels into a one-cycle count strobe and a direction bit. Four resolutions are available: x4, x2, x1, and a direction/clock mode in which one line is the count clock and the other sets the direction. In the quadrature modes, a transition in which both lines change between two filtered samples cannot be decoded. Such a transition is reported on a sticky error flag and produces no count.

The outputs are plain strobes, with no valid/ready handshake. The downstream counter must act on every cycle in which `count_en` is high, because the block cannot be stalled and holds no pending counts. `count_up` has a meaning only in a cycle where `count_en` is high.

Top module: `quad_input_decoder`

## Requirements
- R1: After reset, `count_en` is 0 and `err_flag` is 0.
- R2: A filtered line takes a new level only after the synchronized input has shown that level at two consecutive sample ticks. A level seen at only one tick produces no count.
- R3: A sample tick occurs once every `presc`+1 clock cycles. With `presc`=5, a pulse of 5 cycles is rejected and a pulse of 14 cycles is passed.
- R4: In `mode`=2'b11 (x4), every change of A or B produces one count. The up direction (`count_up`=1) is the one in which A leads B, that is, the AB sequence 00,10,11,01,00. The reverse sequence counts down.
- R5: In `mode`=2'b01 (x1), only a rising edge of A counts. The count is up when B is 0 and down when B is 1.
- R6: In `mode`=2'b10 (x2), both edges of A count and edges of B do not. The count is up when A and B differ after the edge and down when they are equal.
- R7: In `mode`=2'b00 (direction/clock), each rising edge of A is one count, down when B is 1 and up when B is 0. Simultaneous changes of A and B are legal in this mode.
- R8: In any quadrature mode (x1, x2, x4), a filtered step in which A and B change on the same tick produces no count and sets `err_flag`.
- R9: `err_flag` stays set until a cycle with `err_clr` high, after which it reads 0. A new error in the same cycle as the clear wins. Reset also clears it.
- R10: With `presc`=0, `count_en` rises in the fifth cycle after a raw input change and is high for one cycle per count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw encoder line A (count clock in direction/clock mode) |
| enc_b | input | 1 | Raw encoder line B (direction in direction/clock mode) |
| mode | input | 2 | 00 direction/clock, 01 x1, 10 x2, 11 x4 |
| presc | input | PRESC_W (8) | Sample tick divider; tick period is presc+1 cycles |
| err_clr | input | 1 | Clears the sticky error flag |
| count_en | output | 1 | One-cycle count strobe |
| count_up | output | 1 | Direction for the strobe: 1 up, 0 down |
| err_flag | output | 1 | Sticky undecodable-transition flag |

## Verification
The bench builds the block with its defaults: an 8-bit divider and a two-stage synchronizer. It drives `presc` at 0 and at 5. A divider of 0 gives a sample tick on every cycle, which makes the five-cycle latency and the one-cycle versus two-cycle glitch boundary exact. A divider of 5 spaces the ticks apart, so pulse lengths on either side of the two-tick acceptance window can be tried.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    QM_DIRCLK = 2'b00,
    QM_X1     = 2'b01,
    QM_X2     = 2'b10,
    QM_X4     = 2'b11
  } qmode_e;
endpackage

// File: rtl/qdec_prescaler.sv
module qdec_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] presc,
  output logic         tick
);
  logic [W-1:0] cnt;

  // >= keeps the divider safe when presc is lowered below the running count
  assign tick = (cnt >= presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (presc == '0 || !tick)); // R3
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  logic [SYNC-1:0] sync_q;
  logic            samp_q;
  logic            s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], din};
  end

  assign s = sync_q[SYNC-1];

  // accept a level only when two consecutive ticks agree on it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      dout   <= 1'b0;
    end else if (tick) begin
      samp_q <= s;
      if (s == samp_q) dout <= s;
    end
  end

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(dout)); // R2
endmodule

// File: rtl/qdec_decoder.sv
module qdec_decoder
  import qdec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  qmode_e mode,
  input  logic   fa,
  input  logic   fb,
  input  logic   err_clr,
  output logic   count_en,
  output logic   count_up,
  output logic   err_flag
);
  logic fa_d, fb_d;
  logic chg_a, chg_b, quad, illegal;
  logic hit, dir_up;

  assign chg_a   = fa ^ fa_d;
  assign chg_b   = fb ^ fb_d;
  assign quad    = (mode != QM_DIRCLK);
  assign illegal = quad & chg_a & chg_b;

  always_comb begin
    hit    = 1'b0;
    dir_up = 1'b0;
    unique case (mode)
      QM_DIRCLK: begin
        hit    = chg_a & fa;
        dir_up = ~fb;
      end
      QM_X1: begin
        hit    = chg_a & fa & ~chg_b;
        dir_up = ~fb;
      end
      QM_X2: begin
        hit    = chg_a & ~chg_b;
        dir_up = fa ^ fb;
      end
      QM_X4: begin
        hit    = chg_a ^ chg_b;
        dir_up = chg_a ? (fa ^ fb) : ~(fa ^ fb);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_d     <= 1'b0;
      fb_d     <= 1'b0;
      count_en <= 1'b0;
      count_up <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      fa_d     <= fa;
      fb_d     <= fb;
      count_en <= hit;
      count_up <= dir_up;
      if (illegal)      err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end

  AST_ILLEGAL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (err_flag && !count_en)); // R8
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag); // R9
  AST_X1_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && mode == QM_X1 && $past(mode) == QM_X1) |-> fa_d); // R5
  AST_DIRCLK_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && mode == QM_DIRCLK && $past(mode) == QM_DIRCLK) |-> (count_up == !fb_d)); // R7
endmodule

// File: rtl/quad_input_decoder.sv
module quad_input_decoder
  import qdec_pkg::*;
#(
  parameter int PRESC_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_a,
  input  logic               enc_b,
  input  logic [1:0]         mode,
  input  logic [PRESC_W-1:0] presc,
  input  logic               err_clr,
  output logic               count_en,
  output logic               count_up,
  output logic               err_flag
);
  localparam int NCH = 2;

  logic           tick;
  logic [NCH-1:0] raw, clean;

  assign raw = {enc_b, enc_a};

  qdec_prescaler #(.W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .presc (presc),
    .tick  (tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_filt
    qdec_filter #(.SYNC(SYNC_STAGES)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .din   (raw[ch]),
      .dout  (clean[ch])
    );
  end

  qdec_decoder u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (qmode_e'(mode)),
    .fa       (clean[0]),
    .fb       (clean[1]),
    .err_clr  (err_clr),
    .count_en (count_en),
    .count_up (count_up),
    .err_flag (err_flag)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!err_flag || !rst_n)); // R1
endmodule

// File: tb/test_quad_input_decoder.sv
module test_quad_input_decoder;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       enc_a = 0, enc_b = 0;
  logic [1:0] mode = 2'b11;
  logic [7:0] presc = 0;
  logic       err_clr = 0;
  logic       count_en, count_up, err_flag;

  int    checks = 0;
  int    errors = 0;
  bit    exp_q[$];
  string cur_req = "R1";
  bit    done = 0;

  always #5 clk = ~clk;

  quad_input_decoder i_quad_input_decoder (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .mode(mode),
    .presc(presc), .err_clr(err_clr), .count_en(count_en),
    .count_up(count_up), .err_flag(err_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk);
    enc_a = a;
    enc_b = b;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input bit up);
    exp_q.push_back(up);
  endtask

  task automatic step(input logic a, input logic b, input int hold);
    drive(a, b);
    settle(hold);
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // monitor: pops expected directions as strobes appear
  always @(negedge clk) begin
    if (rst_n && count_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected count actual=%0d expected=none", cur_req, count_up);
      end else begin
        automatic bit e = exp_q.pop_front();
        if (count_up != e) begin
          errors++;
          $display("FAIL %s direction actual=%0d expected=%0d", cur_req, count_up, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3);
    check(count_en == 0, "R1", count_en, 0);
    check(err_flag == 0, "R1", err_flag, 0);
    rst_n = 1;
    settle(3);

    // R10 latency, x4, presc 0
    cur_req = "R10";
    mode = 2'b11;
    push(1);
    drive(1, 0);
    settle(4);
    check(count_en == 0, "R10", count_en, 0);
    settle(1);
    check(count_en == 1, "R10", count_en, 1);
    settle(1);
    check(count_en == 0, "R10", count_en, 0);
    push(0);
    step(0, 0, 8);
    drained("R10");

    // R4 x4 up and down
    cur_req = "R4";
    push(1); step(1, 0, 8);
    push(1); step(1, 1, 8);
    push(1); step(0, 1, 8);
    push(1); step(0, 0, 8);
    push(0); step(0, 1, 8);
    push(0); step(1, 1, 8);
    push(0); step(1, 0, 8);
    push(0); step(0, 0, 8);
    drained("R4");

    // R5 x1
    cur_req = "R5";
    mode = 2'b01;
    push(1); step(1, 0, 8);
    step(1, 1, 8); step(0, 1, 8); step(0, 0, 8);
    step(0, 1, 8);
    push(0); step(1, 1, 8);
    step(1, 0, 8); step(0, 0, 8);
    drained("R5");

    // R6 x2
    cur_req = "R6";
    mode = 2'b10;
    push(1); step(1, 0, 8);
    step(1, 1, 8);
    push(1); step(0, 1, 8);
    step(0, 0, 8);
    step(0, 1, 8);
    push(0); step(1, 1, 8);
    step(1, 0, 8);
    push(0); step(0, 0, 8);
    drained("R6");

    // R7 direction/clock
    cur_req = "R7";
    mode = 2'b00;
    push(1); step(1, 0, 8);
    step(0, 0, 8);
    step(0, 1, 8);
    push(0); step(1, 1, 8);
    step(0, 1, 8);
    push(1); step(1, 0, 8);
    check(err_flag == 0, "R7", err_flag, 0);
    step(0, 0, 8);
    drained("R7");

    // R2 glitch boundary, presc 0
    cur_req = "R2";
    mode = 2'b11;
    drive(1, 0); drive(0, 0); settle(8);
    drained("R2");
    push(1); push(0);
    drive(1, 0); settle(1); drive(0, 0); settle(8);
    drained("R2");

    // R3 prescaler 5
    cur_req = "R3";
    presc = 5;
    settle(10);
    drive(1, 0); settle(4); drive(0, 0); settle(30);
    drained("R3");
    push(1); push(0);
    drive(1, 0); settle(13); drive(0, 0); settle(30);
    drained("R3");
    presc = 0;
    settle(10);

    // R8 illegal step in x4
    cur_req = "R8";
    step(1, 1, 8);
    check(err_flag == 1, "R8", err_flag, 1);
    step(0, 0, 8);
    drained("R8");

    // R9 sticky and clear
    cur_req = "R9";
    settle(20);
    check(err_flag == 1, "R9", err_flag, 1);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    check(err_flag == 0, "R9", err_flag, 0);
    step(1, 1, 8);
    check(err_flag == 1, "R9", err_flag, 1);
    rst_n = 0;
    settle(1);
    check(err_flag == 0, "R9", err_flag, 0);
    enc_a = 0; enc_b = 0;
    settle(4);
    rst_n = 1;
    settle(8);
    check(err_flag == 0, "R1", err_flag, 0);
    drained("R9");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule